// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Controller

This block is the target side of a two-wire serial EEPROM. A system clock samples the bus clock and data lines. The block finds start and stop conditions, decodes the device header byte, and collects a two-byte memory address. It then runs byte and page writes, as well as current-address, random and sequential reads. The default build addresses an 8192-byte array with 32-byte pages. The array width and the page size are parameters.

Written bytes go to a separate write-buffer block, one push per byte, each with its address. The buffer gets a commit pulse when the transfer ends with a stop. While the buffer reports that its internal programming cycle is busy, the block refuses every header, so a host can poll for completion. Reads go to a synchronous byte-wide memory with one cycle of latency. The data line is driven only through a pull-low enable, so the block never drives a high level.

The block keeps an address counter between transfers. After a read it advances across the whole array. After a write it advances within the current page only. A random read works as a dummy write of the address, followed by a repeated start and a read header.

Top module: `twi_eeprom_target`

## Requirements
- R1: A start condition (data falling while the bus clock is high) seen in any state drops the current transfer, releases the data line and begins collecting a new header byte. A stop condition (data rising while the clock is high) returns the block to idle.
- R2: The header byte holds the fixed code 1010 in bits 7..4, the strap value in bits 3..1, and the direction in bit 0 (1 = read, 0 = write). The block acknowledges it by pulling the line low on the ninth clock only when the code and the strap both match. On a mismatch it stays released and goes idle.
- R3: While `wbuf_busy_i` is high, no header is acknowledged, even one that matches.
- R4: After a write header, two address bytes follow and each is acknowledged. The low ADDR_W-8 bits of the first byte become the top address bits. Its remaining upper bits are ignored. The second byte gives address bits 7..0.
- R5: Each data byte after the address is acknowledged and pushed to the write buffer with the current address. The address then advances within its page, so the byte after the last location of a page lands on the first location of the same page.
- R6: `wbuf_commit_o` pulses once for a stop that ends a write carrying at least one data byte. A write that carried only an address (a dummy write) produces no commit.
- R7: Read data is shifted out most significant bit first. Each bit changes only after a falling edge of the bus clock. The first byte comes from the current address.
- R8: When the host acknowledges (drives 0) after a read byte, the next byte comes from the following address. Reads wrap from the last array location to location 0.
- R9: After the host declines (drives 1) following a read byte, the block keeps the data line released for any further clocks, until a start or a stop.
- R10: The current address is kept between transfers. It equals the last accessed location plus one, with the page wrap after writes and the full-array wrap after reads.
- R11: After reset the current address is 0 and the data line is released.
- R12: A dummy write that sets the address, followed by a repeated start and a read header, returns data starting at the newly loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| strap_i | input | 3 | Board strap value compared with header bits 3..1 |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| wbuf_busy_i | input | 1 | Write buffer is in its internal programming cycle |
| wbuf_push_o | output | 1 | One-cycle pulse that delivers a write byte |
| wbuf_addr_o | output | ADDR_W | Array address of the pushed byte |
| wbuf_data_o | output | 8 | Pushed data byte |
| wbuf_commit_o | output | 1 | One-cycle pulse that starts programming of the pushed bytes |
| mem_rd_o | output | 1 | Read strobe to the memory |
| mem_addr_o | output | ADDR_W | Read address, valid with the strobe |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the strobe |

## Verification
Several rules are checked by assertions on every cycle. The line pull is only asserted while the bus clock is low. The line stays released whenever the block is idle. A start always brings the block back to header collection. A busy buffer always leads to a refused header. A commit only follows a stop. A page-mode step keeps the upper address bits, and a read step adds exactly one. Other behaviour only shows up in the bench's bus scenarios: whether the address counter carries over correctly between transfers, page overwrite order, the wrap at the end of the array, strap and code mismatches, the dummy write followed by a repeated start, and a silent line after a declined read.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WR,
      ST_RD
   } twi_state_e;

   localparam logic [3:0] DEV_CODE = 4'b1010;
   localparam logic [3:0] ACK_SLOT = 4'd8;
   localparam logic [3:0] ACK_END  = 4'd9;

endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
   logic scl_prev, sda_prev;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twi_line_sampler: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sync <= '1;
         sda_sync <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_sync <= {scl_sync[TOP-1:0], scl_i};
         sda_sync <= {sda_sync[TOP-1:0], sda_i};
         scl_prev <= scl_sync[TOP];
         sda_prev <= sda_sync[TOP];
      end
   end

   assign scl_o      = scl_sync[TOP];
   assign sda_o      = sda_sync[TOP];
   assign scl_rise_o = scl_o & ~scl_prev;
   assign scl_fall_o = ~scl_o & scl_prev;
   assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
   assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;

endmodule

// File: rtl/twi_byte_shifter.sv
module twi_byte_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] load_val_i,
   output logic [BYTE_W-1:0] byte_o
);
   logic [BYTE_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (load_i)  sh_q <= load_val_i;
      else if (shift_i) sh_q <= {sh_q[BYTE_W-2:0], bit_i};
   end

   assign byte_o = sh_q;

endmodule

// File: rtl/twi_addr_counter.sv
module twi_addr_counter #(
   parameter int ADDR_W = 13,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              step_i,
   input  logic              page_mode_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] addr_q, next_rd, next_wr;

   assign next_rd = addr_q + ONE;

   if (PAGE_W == 0) begin : g_no_page
      assign next_wr = next_rd;
   end else if (PAGE_W < ADDR_W) begin : g_page
      assign next_wr = {addr_q[ADDR_W-1:PAGE_W], next_rd[PAGE_W-1:0]};
   end else begin : g_bad_page
      $error("twi_addr_counter: PAGE_W must be below ADDR_W");
      assign next_wr = next_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_q <= '0;
      else if (load_i) addr_q <= load_val_i;
      else if (step_i) addr_q <= page_mode_i ? next_wr : next_rd;
   end

   assign addr_o = addr_q;

   a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && page_mode_i && !load_i) |=>
         addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));

   a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !page_mode_i && !load_i) |=> addr_q == $past(addr_q) + ONE);

endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
   import twi_eep_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int PAGE_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [2:0]        strap_i,
   output logic              sda_pull_o,
   input  logic              wbuf_busy_i,
   output logic              wbuf_push_o,
   output logic [ADDR_W-1:0] wbuf_addr_o,
   output logic [7:0]        wbuf_data_o,
   output logic              wbuf_commit_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [7:0]        mem_rdata_i
);
   localparam int HI_W = ADDR_W - 8;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("twi_eeprom_target: ADDR_W must lie in 9..16");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

   twi_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_o(scl_lvl), .sda_o(sda_lvl), .scl_rise_o(scl_rise),
      .scl_fall_o(scl_fall), .start_o(start_ev), .stop_o(stop_ev)
   );

   twi_state_e        state_q;
   logic [3:0]        cnt_q;
   logic              pull_q, rw_q, wrote_q, mack_q, fetch_q;
   logic              push_q, commit_q, rd_q;
   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] waddr_q, cur_addr;
   logic [7:0]        wdata_q, byte_w;

   logic receiving, no_cond, shift_en, decide, dev_ok, addr_load, step_wr;
   logic [2:0] tx_idx;

   assign receiving = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                      (state_q == ST_ALO) || (state_q == ST_WR);
   assign no_cond   = !start_ev && !stop_ev;
   assign shift_en  = receiving && scl_rise && (cnt_q < ACK_SLOT) && no_cond;
   assign decide    = receiving && scl_fall && (cnt_q == ACK_SLOT) && no_cond;
   assign dev_ok    = (byte_w[7:4] == DEV_CODE) && (byte_w[3:1] == strap_i) &&
                      !wbuf_busy_i;
   assign addr_load = decide && (state_q == ST_ALO);
   assign step_wr   = decide && (state_q == ST_WR);
   assign tx_idx    = 3'(4'd7 - cnt_q);

   twi_byte_shifter #(.BYTE_W(8)) u_shifter (
      .clk(clk), .rst_n(rst_n), .shift_i(shift_en), .bit_i(sda_lvl),
      .load_i(fetch_q), .load_val_i(mem_rdata_i), .byte_o(byte_w)
   );

   twi_addr_counter #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(addr_load),
      .load_val_i({hi_q, byte_w}), .step_i(step_wr || fetch_q),
      .page_mode_i(step_wr), .addr_o(cur_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         pull_q   <= 1'b0;
         rw_q     <= 1'b0;
         wrote_q  <= 1'b0;
         mack_q   <= 1'b0;
         fetch_q  <= 1'b0;
         push_q   <= 1'b0;
         commit_q <= 1'b0;
         rd_q     <= 1'b0;
         hi_q     <= '0;
         waddr_q  <= '0;
         wdata_q  <= '0;
      end else begin
         push_q   <= 1'b0;
         commit_q <= 1'b0;
         rd_q     <= 1'b0;
         fetch_q  <= rd_q;
         if (start_ev) begin
            state_q <= ST_DEV;
            cnt_q   <= '0;
            pull_q  <= 1'b0;
            wrote_q <= 1'b0;
         end else if (stop_ev) begin
            commit_q <= (state_q == ST_WR) && wrote_q;
            state_q  <= ST_IDLE;
            pull_q   <= 1'b0;
            wrote_q  <= 1'b0;
         end else if (receiving) begin
            if (shift_en) begin
               cnt_q <= cnt_q + 4'd1;
            end else if (decide) begin
               cnt_q  <= ACK_END;
               pull_q <= 1'b1;
               case (state_q)
                  ST_DEV: begin
                     if (dev_ok) begin
                        rw_q <= byte_w[0];
                        rd_q <= byte_w[0];
                     end else begin
                        state_q <= ST_IDLE;
                        pull_q  <= 1'b0;
                     end
                  end
                  ST_AHI: hi_q <= byte_w[HI_W-1:0];
                  ST_WR: begin
                     push_q  <= 1'b1;
                     waddr_q <= cur_addr;
                     wdata_q <= byte_w;
                     wrote_q <= 1'b1;
                  end
                  default: ;
               endcase
            end else if (scl_fall && cnt_q == ACK_END) begin
               cnt_q  <= '0;
               pull_q <= 1'b0;
               case (state_q)
                  ST_DEV: begin
                     state_q <= rw_q ? ST_RD : ST_AHI;
                     pull_q  <= rw_q & ~byte_w[7];
                  end
                  ST_AHI:  state_q <= ST_ALO;
                  default: state_q <= ST_WR;
               endcase
            end
         end else if (state_q == ST_RD) begin
            if (scl_rise && cnt_q < ACK_SLOT) begin
               cnt_q <= cnt_q + 4'd1;
            end else if (scl_rise && cnt_q == ACK_SLOT) begin
               mack_q <= ~sda_lvl;
               rd_q   <= ~sda_lvl;
               cnt_q  <= ACK_END;
            end else if (scl_fall && cnt_q == ACK_SLOT) begin
               pull_q <= 1'b0;
            end else if (scl_fall && cnt_q == ACK_END) begin
               if (mack_q) begin
                  pull_q <= ~byte_w[7];
                  cnt_q  <= '0;
               end else begin
                  state_q <= ST_IDLE;
               end
            end else if (scl_fall && cnt_q != 4'd0) begin
               pull_q <= ~byte_w[tx_idx];
            end
         end
      end
   end

   assign sda_pull_o    = pull_q;
   assign wbuf_push_o   = push_q;
   assign wbuf_addr_o   = waddr_q;
   assign wbuf_data_o   = wdata_q;
   assign wbuf_commit_o = commit_q;
   assign mem_rd_o      = rd_q;
   assign mem_addr_o    = cur_addr;

   // R7 / open-drain rule: the pull may only turn on while the clock is low
   a_r7_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_q && !$past(pull_q)) |-> !scl_lvl);

   a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (state_q == ST_DEV && cnt_q == 4'd0 && !pull_q));

   a_r3_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && state_q == ST_DEV && wbuf_busy_i) |=>
         (!pull_q && state_q == ST_IDLE));

   a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !pull_q);

   a_r6_commit_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> $past(stop_ev));

   a_r5_push_read_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_q && rd_q));

endmodule

// File: tb/twi_eeprom_target_bench.sv
`timescale 1ns/1ps
module twi_eeprom_target_bench;
   localparam int ADDR_W = 9;
   localparam int PAGE_W = 3;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PAGE   = 1 << PAGE_W;
   localparam int Q      = 100;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_pull, push, commit, mem_rd;
   logic [ADDR_W-1:0] waddr, mem_addr;
   logic [7:0] wdata;
   logic [7:0] rdata = 8'h00;
   logic busy;
   wire  sda_bus = m_sda & ~sda_pull;

   always #10 clk = ~clk;

   twi_eeprom_target #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC_STAGES(2)) u_twi_eeprom_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(STRAP),
      .sda_pull_o(sda_pull), .wbuf_busy_i(busy), .wbuf_push_o(push),
      .wbuf_addr_o(waddr), .wbuf_data_o(wdata), .wbuf_commit_o(commit),
      .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(rdata)
   );

   // memory, write buffer and programming-cycle model
   logic [7:0] mem  [DEPTH];
   logic [7:0] gold [DEPTH];
   logic [ADDR_W-1:0] p_addr [64];
   logic [7:0] p_data [64];
   int np = 0;
   int busy_cnt = 0;
   int n_commit = 0;
   assign busy = (busy_cnt != 0);

   always @(posedge clk) begin
      if (mem_rd) rdata <= mem[mem_addr];
      if (push) begin
         p_addr[np] <= waddr;
         p_data[np] <= wdata;
         np <= np + 1;
      end
      if (commit) begin
         for (int k = 0; k < np; k++) mem[p_addr[k]] <= p_data[k];
         np <= 0;
         busy_cnt <= 1500;
         n_commit <= n_commit + 1;
      end else if (busy_cnt > 0) begin
         busy_cnt <= busy_cnt - 1;
      end
   end

   int n_total = 0;
   int n_fail  = 0;
   int cur_exp = 0;

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic i2c_start();
      scl = 1'b0; #(Q);
      m_sda = 1'b1; #(Q);
      scl = 1'b1; #(2*Q);
      m_sda = 1'b0; #(2*Q);
      scl = 1'b0; #(Q);
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; #(Q);
      scl = 1'b1; #(2*Q);
      m_sda = 1'b1; #(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack_n);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; #(Q);
         scl = 1'b1; #(2*Q);
         scl = 1'b0; #(Q);
      end
      m_sda = 1'b1; #(Q);
      scl = 1'b1; #(Q);
      ack_n = sda_bus; #(Q);
      scl = 1'b0; #(Q);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         #(Q); scl = 1'b1;
         #(Q); b[i] = sda_bus;
         #(Q); scl = 1'b0;
         #(Q);
      end
      m_sda = nack; #(Q);
      scl = 1'b1; #(2*Q);
      scl = 1'b0; #(Q);
      m_sda = 1'b1;
   endtask

   function automatic logic [7:0] hdr(input logic rd);
      return {4'b1010, STRAP, rd};
   endfunction

   // read n bytes from the current address, acknowledging all but the last
   task automatic read_cur(input int n, input string req);
      logic a;
      logic [7:0] b;
      i2c_start();
      send_byte(hdr(1'b1), a);
      chk(a == 1'b0, "R2", a, 0);
      for (int k = 0; k < n; k++) begin
         recv_byte(k == n - 1, b);
         chk(b == gold[cur_exp], req, b, gold[cur_exp]);
         cur_exp = (cur_exp + 1) % DEPTH;
      end
      i2c_stop();
   endtask

   // header plus both address bytes; upper bits of the first byte are junk
   task automatic set_addr(input int addr);
      logic a;
      logic [7:0] hi;
      hi = {7'b1110000, 1'(addr >> 8)};
      i2c_start();
      send_byte(hdr(1'b0), a);
      chk(a == 1'b0, "R2", a, 0);
      send_byte(hi, a);
      chk(a == 1'b0, "R4", a, 0);
      send_byte(8'(addr), a);
      chk(a == 1'b0, "R4", a, 0);
   endtask

   task automatic write_bytes(input int addr, input int n, input logic [7:0] base);
      logic a;
      int wa;
      set_addr(addr);
      wa = addr;
      for (int k = 0; k < n; k++) begin
         send_byte(base + 8'(k), a);
         chk(a == 1'b0, "R5", a, 0);
         gold[wa] = base + 8'(k);
         wa = (wa & ~(PAGE - 1)) | ((wa + 1) & (PAGE - 1));
      end
      cur_exp = wa;
      i2c_stop();
   endtask

   // poll with write headers until acknowledged; returns refusal count
   task automatic wait_ready(output int refused);
      logic a;
      refused = 0;
      for (int t = 0; t < 200; t++) begin
         i2c_start();
         send_byte(hdr(1'b0), a);
         i2c_stop();
         if (a == 1'b0) break;
         refused++;
         #(10*Q);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] b;
      int refused, c0;
      logic quiet;
      for (int i = 0; i < DEPTH; i++) begin
         mem[i]  = 8'(i * 37 + 11);
         gold[i] = 8'(i * 37 + 11);
      end
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(sda_pull == 1'b0, "R11", sda_pull, 0);
      rst_n = 1'b1;
      #(10*Q);

      // R11: first current read after reset comes from location 0
      cur_exp = 0;
      read_cur(1, "R11");

      // R2: strap mismatch and code mismatch are refused
      i2c_start();
      send_byte({4'b1010, 3'b110, 1'b0}, a);
      chk(a == 1'b1, "R2 strap mismatch", a, 1);
      i2c_stop();
      i2c_start();
      send_byte({4'b1011, STRAP, 1'b1}, a);
      chk(a == 1'b1, "R2 code mismatch", a, 1);
      i2c_stop();

      // R4, R5, R6: single byte write with junk in the first address byte
      c0 = n_commit;
      write_bytes(9'h1A5, 1, 8'h3C);
      #(2*Q);
      chk(n_commit == c0 + 1, "R6 commit", n_commit, c0 + 1);

      // R3: refused while the programming cycle runs
      wait_ready(refused);
      chk(refused > 0, "R3 busy refusal", refused, 1);
      chk(!busy, "R3 ready after poll", busy, 0);

      // R10: current address follows the write
      read_cur(1, "R10");
      // R12: random reads
      set_addr(9'h1A5); cur_exp = 9'h1A5;
      read_cur(1, "R12 written byte");
      set_addr(9'h050); cur_exp = 9'h050;
      read_cur(1, "R12");

      // R8: sequential read across the end of the array
      set_addr(9'h1FE); cur_exp = 9'h1FE;
      read_cur(4, "R8 wrap");
      chk(n_commit == c0 + 1, "R6 dummy write", n_commit, c0 + 1);

      // R5: page write of 10 bytes overwrites within one page
      write_bytes(9'h0C5, 10, 8'hA0);
      wait_ready(refused);
      read_cur(1, "R10 page wrap");
      set_addr(9'h0C0); cur_exp = 9'h0C0;
      read_cur(PAGE, "R5 page");

      // R9: after a decline the line stays released
      i2c_start();
      send_byte(hdr(1'b1), a);
      chk(a == 1'b0, "R2", a, 0);
      recv_byte(1'b1, b);
      chk(b == gold[cur_exp], "R7", b, gold[cur_exp]);
      cur_exp = (cur_exp + 1) % DEPTH;
      quiet = 1'b1;
      for (int k = 0; k < 9; k++) begin
         #(Q); scl = 1'b1;
         #(Q); if (sda_bus != 1'b1) quiet = 1'b0;
         #(Q); scl = 1'b0;
         #(Q);
      end
      chk(quiet, "R9", quiet, 1);
      i2c_stop();

      // R1: a start after a partial address drops it; address unchanged
      i2c_start();
      send_byte(hdr(1'b0), a);
      send_byte(8'h00, a);
      read_cur(2, "R1 restart");

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule